// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block sits between an on-chip host and a three-wire serial EEPROM. The host hands over one command at a time: a command code, a word address and, for writes, a data word. The engine sends the command bit by bit on the serial lines, returns the word for a read, and raises a one-cycle completion pulse once the bus is free for the next command.

Every command goes out as one frame while chip select is high. The engine produces the serial clock by dividing the system clock. For commands that program the array, it does not wait a fixed time. It drops chip select for the minimum low interval, raises it again and watches the device data line until the device reports ready. If the device does not report ready within a set number of samples, the engine ends the command with a timeout flag.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, and while idle, `cs_o`, `sclk_o`, `ser_do_o`, `done_o` and `timeout_o` are low and `req_ready_o` is high.
- R2: A frame is a 1 start bit, then a 2-bit opcode, then the address MSB first, then write data MSB first. The opcodes are read = 10, write = 01, erase = 11 and extended = 00. Host command codes on `req_cmd_i` are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 write-enable and 6 write-disable.
- R3: Extended commands send opcode 00 and carry a sub-code in the two most significant address bits: erase-all 10, write-all 01, enable 11 and disable 00. The remaining address bits are sent as 0. Write-all is followed by its data word. Command code 7 is sent exactly like write-disable.
- R4: The number of rising `sclk_o` edges per frame is 3+ADDR_W for erase, erase-all, enable and disable. It is 3+ADDR_W+WORD_W for read, write and write-all, which gives 11 and 27 at the default widths.
- R5: `ser_do_o` changes only while `sclk_o` is low. Each high and each low phase of `sclk_o` lasts at least CLK_DIV system cycles. `sclk_o` is low whenever `cs_o` is low.
- R6: A read returns in `rdata_o` the last WORD_W bits sampled from `ser_di_i`, MSB first. The dummy 0 bit that the device sends after the address is dropped. `rdata_o` is valid with `done_o`.
- R7: Between any two high intervals of `cs_o`, `cs_o` stays low for at least CSL_CYC system cycles.
- R8: After write, erase, erase-all or write-all, the engine raises `cs_o` again and samples `ser_di_i` once per divider period. Low means busy and high means ready. `done_o` comes only after a high sample, with `timeout_o` low.
- R9: If POLL_MAX samples in a row are low, the engine releases `cs_o` and signals `done_o` together with `timeout_o` high.
- R10: A request is taken only when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from acceptance until completion. `done_o` is a single-cycle pulse, issued with `cs_o` low, in the same cycle that `req_ready_o` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Engine can take a request |
| req_cmd_i | input | 3 | Command code |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | WORD_W | Data word for write and write-all |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | WORD_W | Read result, valid with done_o |
| timeout_o | output | 1 | Ready polling timed out, valid with done_o |
| cs_o | output | 1 | Device chip select, active high |
| sclk_o | output | 1 | Serial clock |
| ser_do_o | output | 1 | Serial data to the device |
| ser_di_i | input | 1 | Serial data and ready status from the device |

## Verification
A model of the device on the bench captures each frame and stores words. Directed commands cover both address boundaries and all-zero, all-one and alternating data words. They show whether the opcode, address and data fields are laid out and ordered correctly, and whether the read result is aligned around the dummy bit. A seeded random mix of reads, writes, erases, enables and disables then runs against a reference copy of the memory. It exposes swapped sub-codes, a lost enable state and off-by-one bit counts. A device that stays busy separates correct ready polling from the timeout path.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    CMD_READ       = 3'd0,
    CMD_WRITE      = 3'd1,
    CMD_ERASE      = 3'd2,
    CMD_ERASE_ALL  = 3'd3,
    CMD_WRITE_ALL  = 3'd4,
    CMD_WR_ENABLE  = 3'd5,
    CMD_WR_DISABLE = 3'd6
  } uw_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } uw_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_EXT   = 2'b00;

  localparam logic [1:0] SUB_ERASE_ALL = 2'b10;
  localparam logic [1:0] SUB_WRITE_ALL = 2'b01;
  localparam logic [1:0] SUB_ENABLE    = 2'b11;
  localparam logic [1:0] SUB_DISABLE   = 2'b00;

endpackage

// File: rtl/uwire_frame.sv
module uwire_frame import uwire_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [2:0]                   cmd_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [3+ADDR_W+WORD_W-1:0]   frame_o,
  output logic [CNT_W-1:0]             nclk_o,
  output logic                         prog_o,
  output logic                         rd_o
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;

  logic [1:0]        op, sub;
  logic              ext, with_data;
  logic [ADDR_W-1:0] afield;

  always_comb begin
    op        = OP_EXT;
    sub       = SUB_DISABLE;
    ext       = 1'b1;
    with_data = 1'b0;
    prog_o    = 1'b0;
    rd_o      = 1'b0;
    case (uw_cmd_e'(cmd_i))
      CMD_READ:      begin op = OP_READ;  ext = 1'b0; rd_o = 1'b1; end
      CMD_WRITE:     begin op = OP_WRITE; ext = 1'b0; with_data = 1'b1; prog_o = 1'b1; end
      CMD_ERASE:     begin op = OP_ERASE; ext = 1'b0; prog_o = 1'b1; end
      CMD_ERASE_ALL: begin sub = SUB_ERASE_ALL; prog_o = 1'b1; end
      CMD_WRITE_ALL: begin sub = SUB_WRITE_ALL; with_data = 1'b1; prog_o = 1'b1; end
      CMD_WR_ENABLE: sub = SUB_ENABLE;
      default:       sub = SUB_DISABLE;
    endcase
    afield  = ext ? {sub, {(ADDR_W-2){1'b0}}} : addr_i;
    frame_o = {1'b1, op, afield, (with_data ? wdata_i : {WORD_W{1'b0}})};
    nclk_o  = (with_data || rd_o) ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
  end

endmodule

// File: rtl/uwire_tick.sv
module uwire_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/uwire_timer.sv
module uwire_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl import uwire_pkg::*; #(
  parameter int CLK_DIV  = 4,
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 16,
  parameter int CSL_CYC  = 13,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              timeout_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              ser_do_o,
  input  logic              ser_di_i
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CSL_W   = $clog2(CSL_CYC + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);

  uw_state_e          state_q;
  logic [FRAME_W-1:0] shreg_q, frame_w;
  logic [CNT_W-1:0]   cnt_q, nclk_w;
  logic [WORD_W-1:0]  rdsh_q, rdata_q;
  logic prog_w, rd_w, prog_q, rd_q;
  logic cs_q, sclk_q, done_q, to_q;
  logic tick, run, gap_done, poll_last;
  logic accept, shift_fin, poll_exit, gap_load, poll_load, poll_en;

  uwire_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_frame (
    .cmd_i   (req_cmd_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .frame_o (frame_w),
    .nclk_o  (nclk_w),
    .prog_o  (prog_w),
    .rd_o    (rd_w)
  );

  assign run = (state_q == ST_SHIFT) || (state_q == ST_POLL);

  uwire_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  assign accept    = (state_q == ST_IDLE) && gap_done && req_valid_i;
  assign shift_fin = (state_q == ST_SHIFT) && tick && sclk_q && (cnt_q == '0);
  assign poll_exit = (state_q == ST_POLL) && tick && (ser_di_i || poll_last);
  assign gap_load  = shift_fin || poll_exit;
  assign poll_load = (state_q == ST_GAP) && gap_done && prog_q;
  assign poll_en   = (state_q == ST_POLL) && tick;

  // minimum deselect interval
  uwire_timer #(.W(CSL_W)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .en_i   (1'b1),
    .val_i  (CSL_W'(CSL_CYC)),
    .done_o (gap_done)
  );

  // ready-poll sample budget
  uwire_timer #(.W(POLL_W)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (poll_load),
    .en_i   (poll_en),
    .val_i  (POLL_W'(POLL_MAX - 1)),
    .done_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      rdsh_q  <= '0;
      rdata_q <= '0;
      prog_q  <= 1'b0;
      rd_q    <= 1'b0;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            shreg_q <= frame_w;
            cnt_q   <= nclk_w;
            prog_q  <= prog_w;
            rd_q    <= rd_w;
            to_q    <= 1'b0;
            cs_q    <= 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              cnt_q  <= cnt_q - 1'b1;
            end else begin
              // device output settles after the rising edge; take it at the fall
              sclk_q <= 1'b0;
              rdsh_q <= {rdsh_q[WORD_W-2:0], ser_di_i};
              if (cnt_q == '0) begin
                if (rd_q) rdata_q <= {rdsh_q[WORD_W-2:0], ser_di_i};
                shreg_q <= '0;
                cs_q    <= 1'b0;
                state_q <= ST_GAP;
              end else begin
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            if (prog_q) begin
              prog_q  <= 1'b0;
              cs_q    <= 1'b1;
              state_q <= ST_POLL;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_POLL: begin
          if (poll_exit) begin
            to_q    <= !ser_di_i;
            cs_q    <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE) && gap_done;
  assign done_o      = done_q;
  assign timeout_o   = done_q && to_q;
  assign rdata_o     = rdata_q;
  assign cs_o        = cs_q;
  assign sclk_o      = sclk_q;
  assign ser_do_o    = shreg_q[FRAME_W-1];

endmodule

// File: rtl/uwire_eeprom_ctrl_chk.sv
module uwire_eeprom_ctrl_chk #(
  parameter int CLK_DIV  = 4,
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 16,
  parameter int CSL_CYC  = 13,
  parameter int POLL_MAX = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        req_cmd_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [WORD_W-1:0] req_wdata_i,
  input logic              done_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              timeout_o,
  input logic              cs_o,
  input logic              sclk_o,
  input logic              ser_do_o,
  input logic              ser_di_i
);
  localparam int PH_W  = $clog2(CLK_DIV + 1);
  localparam int GAP_W = $clog2(CSL_CYC + 1);

  logic [PH_W-1:0]  ph_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_cnt  <= PH_W'(CLK_DIV);
      gap_cnt <= GAP_W'(CSL_CYC);
      sclk_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d)               ph_cnt <= PH_W'(1);
      else if (ph_cnt != PH_W'(CLK_DIV))  ph_cnt <= ph_cnt + 1'b1;
      if (cs_o)                           gap_cnt <= '0;
      else if (gap_cnt != GAP_W'(CSL_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_sclk_low_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o);

  p_do_stable_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(ser_do_o));

  p_sclk_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_d) |-> (ph_cnt >= PH_W'(CLK_DIV)));

  p_cs_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (gap_cnt >= GAP_W'(CSL_CYC)));

  p_no_ready_selected_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !req_ready_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_o && req_ready_o));

  p_timeout_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

endmodule

bind uwire_eeprom_ctrl uwire_eeprom_ctrl_chk #(
  .CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
  .CSL_CYC(CSL_CYC), .POLL_MAX(POLL_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
  .done_o(done_o), .rdata_o(rdata_o), .timeout_o(timeout_o), .cs_o(cs_o),
  .sclk_o(sclk_o), .ser_do_o(ser_do_o), .ser_di_i(ser_di_i)
);

// File: tb/uwire_eeprom_ctrl_tb.sv
module uwire_eeprom_ctrl_tb;
  localparam int CLK_DIV  = 2;
  localparam int ADDR_W   = 8;
  localparam int WORD_W   = 16;
  localparam int CSL_CYC  = 13;
  localparam int POLL_MAX = 40;
  localparam int BUSY_CYC = 60;
  localparam int HDR      = 3 + ADDR_W;
  localparam int FR       = HDR + WORD_W;
  localparam int DEPTH    = 1 << ADDR_W;

  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_ERAL = 3'd3,
                         C_WRAL = 3'd4, C_EN = 3'd5, C_DIS = 3'd6, C_BAD = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, done, timeout, cs, sclk, sdo, sdi;
  logic [WORD_W-1:0] rdata;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uwire_eeprom_ctrl #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
                      .CSL_CYC(CSL_CYC), .POLL_MAX(POLL_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .timeout_o(timeout),
    .cs_o(cs), .sclk_o(sclk), .ser_do_o(sdo), .ser_di_i(sdi)
  );

  // ---------------- device model ----------------
  logic [WORD_W-1:0] m_mem [DEPTH];
  logic [63:0] m_cap = '0, m_last_cap = '0;
  int m_cnt = 0, m_last_cnt = 0, m_stamp = -100000;
  logic m_wen = 1'b0, m_rd = 1'b0, m_dout = 1'b0, stuck = 1'b0;
  logic [WORD_W-1:0] m_rsh = '0;
  logic m_busy;

  assign m_busy = (cyc - m_stamp) < BUSY_CYC;
  assign sdi = m_rd ? m_dout : (cs && !(stuck || m_busy));

  always @(posedge sclk or negedge cs) begin
    if (!cs) begin
      if (m_cnt > 0) begin
        logic [1:0] op, sub;
        logic [ADDR_W-1:0] a;
        logic [WORD_W-1:0] d;
        m_last_cap = m_cap;
        m_last_cnt = m_cnt;
        if (m_cnt == HDR) begin
          op = m_cap[HDR-2 -: 2]; a = m_cap[ADDR_W-1:0]; sub = m_cap[ADDR_W-1 -: 2];
          if (op == 2'b11) begin
            m_stamp = cyc; if (m_wen) m_mem[a] = '1;
          end else if (op == 2'b00) begin
            if (sub == 2'b10) begin
              m_stamp = cyc;
              if (m_wen) for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
            end else if (sub == 2'b11) m_wen = 1'b1;
            else if (sub == 2'b00) m_wen = 1'b0;
          end
        end else if (m_cnt == FR) begin
          op = m_cap[FR-2 -: 2]; a = m_cap[WORD_W +: ADDR_W];
          d = m_cap[WORD_W-1:0]; sub = m_cap[WORD_W+ADDR_W-1 -: 2];
          if (op == 2'b01) begin
            m_stamp = cyc; if (m_wen) m_mem[a] = d;
          end else if (op == 2'b00 && sub == 2'b01) begin
            m_stamp = cyc;
            if (m_wen) for (int i = 0; i < DEPTH; i++) m_mem[i] = d;
          end
        end
      end
      m_cnt = 0; m_cap = '0; m_rd = 1'b0; m_dout = 1'b0;
    end else begin
      m_cap = {m_cap[62:0], sdo};
      m_cnt++;
      if (m_cnt == HDR && m_cap[HDR-2 -: 2] == 2'b10) begin
        m_rd = 1'b1; m_rsh = m_mem[m_cap[ADDR_W-1:0]]; m_dout = 1'b0;
      end else if (m_rd && m_cnt > HDR) begin
        m_dout = m_rsh[WORD_W-1]; m_rsh = {m_rsh[WORD_W-2:0], 1'b0};
      end
    end
  end

  // ---------------- bench monitors ----------------
  int r7_viol = 0, r5_viol = 0, low_cnt = CSL_CYC;
  logic cs_d = 1'b0, sclk_d = 1'b0, sdo_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs && !cs_d && low_cnt < CSL_CYC) r7_viol++;
      if (sclk && sclk_d && sdo != sdo_d) r5_viol++;
      if (!cs && sclk) r5_viol++;
      low_cnt = cs ? 0 : low_cnt + 1;
    end
    cs_d = cs; sclk_d = sclk; sdo_d = sdo;
  end

  // ---------------- reference ----------------
  logic [WORD_W-1:0] ref_mem [DEPTH];
  logic ref_wen = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] c);
    return (c == C_RD || c == C_WR || c == C_WRAL) ? FR : HDR;
  endfunction

  function automatic bit is_prog(input logic [2:0] c);
    return (c == C_WR || c == C_ER || c == C_ERAL || c == C_WRAL);
  endfunction

  function automatic logic [63:0] exp_frame(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                                            input logic [WORD_W-1:0] d);
    logic [1:0] op, sub; bit ext, dat;
    logic [ADDR_W-1:0] af; logic [HDR-1:0] hdr;
    op = 2'b00; sub = 2'b00; ext = 1; dat = 0;
    case (c)
      C_RD:   begin op = 2'b10; ext = 0; end
      C_WR:   begin op = 2'b01; ext = 0; dat = 1; end
      C_ER:   begin op = 2'b11; ext = 0; end
      C_ERAL: sub = 2'b10;
      C_WRAL: begin sub = 2'b01; dat = 1; end
      C_EN:   sub = 2'b11;
      default: sub = 2'b00;
    endcase
    af  = ext ? {sub, {(ADDR_W-2){1'b0}}} : a;
    hdr = {1'b1, op, af};
    if (exp_len(c) == HDR) return 64'(hdr);
    return (64'(hdr) << WORD_W) | (dat ? 64'(d) : 64'd0);
  endfunction

  task automatic ref_update(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                            input logic [WORD_W-1:0] d);
    case (c)
      C_WR:   if (ref_wen) ref_mem[a] = d;
      C_ER:   if (ref_wen) ref_mem[a] = '1;
      C_ERAL: if (ref_wen) for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
      C_WRAL: if (ref_wen) for (int i = 0; i < DEPTH; i++) ref_mem[i] = d;
      C_EN:   ref_wen = 1'b1;
      C_DIS, C_BAD: ref_wen = 1'b0;
      default: ;
    endcase
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                        input logic [WORD_W-1:0] d, input bit exp_to);
    logic [63:0] ef, mask; int el;
    logic [WORD_W-1:0] got_rd; logic got_to;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && cs, "R10", "ready low and selected after accept",
        {62'd0, req_ready, cs}, 64'd1);
    while (!done) @(negedge clk);
    got_rd = rdata; got_to = timeout;
    chk(!cs && req_ready, "R10", "released at done", {62'd0, cs, req_ready}, 64'd1);
    el = exp_len(c); ef = exp_frame(c, a, d); mask = (64'd1 << el) - 64'd1;
    chk(m_last_cnt == el, "R4", "rising edges in frame", 64'(m_last_cnt), 64'(el));
    if (c >= C_ERAL) chk((m_last_cap & mask) == ef, "R3", "extended frame bits", m_last_cap & mask, ef);
    else             chk((m_last_cap & mask) == ef, "R2", "frame bits", m_last_cap & mask, ef);
    if (is_prog(c)) begin
      if (exp_to) chk(got_to == 1'b1, "R9", "timeout flag", 64'(got_to), 64'd1);
      else begin
        chk(got_to == 1'b0, "R8", "timeout flag", 64'(got_to), 64'd0);
        chk(!m_busy, "R8", "device busy at done", 64'(m_busy), 64'd0);
      end
    end
    if (c == C_RD) chk(got_rd == ref_mem[a], "R6", "read data", 64'(got_rd), 64'(ref_mem[a]));
    ref_update(c, a, d);
    @(negedge clk);
    chk(!done && !timeout, "R10", "done pulse width", {62'd0, done, timeout}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_mem[i]   = WORD_W'(i * 16'h0123 ^ 16'h5A5A);
      ref_mem[i] = WORD_W'(i * 16'h0123 ^ 16'h5A5A);
    end
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    chk({cs, sclk, sdo, done, timeout, req_ready} == 6'b000001, "R1", "reset outputs",
        64'({cs, sclk, sdo, done, timeout, req_ready}), 64'b000001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs, sclk, sdo, done, timeout, req_ready} == 6'b000001, "R1", "idle outputs",
        64'({cs, sclk, sdo, done, timeout, req_ready}), 64'b000001);

    // writes while disabled leave the array unchanged
    do_cmd(C_DIS, 8'h00, '0, 0);
    do_cmd(C_WR, 8'h10, 16'h1234, 0);
    do_cmd(C_RD, 8'h10, '0, 0);
    // enable, boundary addresses and data corners
    do_cmd(C_EN, 8'h00, '0, 0);
    do_cmd(C_WR, 8'h00, 16'h0000, 0);
    do_cmd(C_WR, 8'hFF, 16'hFFFF, 0);
    do_cmd(C_WR, 8'h80, 16'h8001, 0);
    do_cmd(C_WR, 8'h55, 16'hAAAA, 0);
    do_cmd(C_RD, 8'h00, '0, 0);
    do_cmd(C_RD, 8'hFF, '0, 0);
    do_cmd(C_RD, 8'h80, '0, 0);
    do_cmd(C_RD, 8'h55, '0, 0);
    do_cmd(C_ER, 8'h80, '0, 0);
    do_cmd(C_RD, 8'h80, '0, 0);
    // unused code acts as disable
    do_cmd(C_BAD, 8'h3C, '0, 0);
    do_cmd(C_WR, 8'h01, 16'h0F0F, 0);
    do_cmd(C_RD, 8'h01, '0, 0);
    // random mix
    do_cmd(C_EN, 8'h00, '0, 0);
    for (int k = 0; k < 40; k++) begin
      int unsigned r;
      logic [2:0] c;
      r = $urandom % 8;
      c = (r < 3) ? C_RD : (r < 5) ? C_WR : (r == 5) ? C_ER : (r == 6) ? C_EN : C_DIS;
      do_cmd(c, ADDR_W'($urandom), WORD_W'($urandom), 0);
    end
    // bulk commands
    do_cmd(C_EN, 8'h00, '0, 0);
    do_cmd(C_ERAL, 8'h00, '0, 0);
    do_cmd(C_RD, 8'h37, '0, 0);
    do_cmd(C_WRAL, 8'h00, 16'hC3A5, 0);
    do_cmd(C_RD, 8'h00, '0, 0);
    do_cmd(C_RD, 8'hFE, '0, 0);
    // device that never reports ready
    stuck = 1'b1;
    do_cmd(C_WR, 8'h20, 16'h7E81, 1);
    stuck = 1'b0;
    do_cmd(C_RD, 8'h20, '0, 0);

    chk(r7_viol == 0, "R7", "short deselect intervals", 64'(r7_viol), 64'd0);
    chk(r5_viol == 0, "R5", "data or clock moved at the wrong time", 64'(r5_viol), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule